// File: doc/BRIEF.md
# Two-Loop Timing Servo Lock Sequencer

This block supervises the servo of a timing node that steers its local oscillator with two control loops. The inner loop corrects frequency. The outer loop aligns phase. Error samples come from an external phase measurement engine, and each one arrives with a strobe. The sequencer brings the frequency loop up first. It enables the phase loop only after frequency lock has held for a run of consecutive samples. It declares full lock only after a complete window of phase samples has a small peak-to-peak spread.

Each loop runs its own proportional-integral update with saturating signed arithmetic. The gains are given as right-shift amounts, and each loop has its own pair. When the reference disappears, the block enters holdover. In holdover the frequency command is pinned to its integrator value and the phase command no longer moves. When the reference comes back, or after a restart request, the node converges again through the full staged sequence.

Top module: `servo_lock_seq`

## Requirements
- R1: After reset, state_o is IDLE (code 0), both loop enables are low, and both control outputs are zero. The state codes are IDLE=0, FREQ_ACQ=1, FREQ_LOCK=2, PHASE_ACQ=3, LOCKED=4 and HOLDOVER=5.
- R2: From IDLE, with ref_ok_i high, the next cycle is FREQ_ACQ. In that state only freq_loop_en_o is high.
- R3: In FREQ_ACQ, a sample counts as good when |freq_err_i| < freq_thr_i. A bad sample clears the run. The FREQ_N-th good sample in a row moves the state to FREQ_LOCK.
- R4: FREQ_LOCK moves on the next sample: to PHASE_ACQ if that sample's frequency error is good, otherwise back to FREQ_ACQ. phase_loop_en_o is high only in PHASE_ACQ and LOCKED.
- R5: In PHASE_ACQ and LOCKED, good samples fill windows of PHASE_M phase samples. At the end of each window the spread (max − min) is compared with phase_thr_i. A spread below the threshold moves PHASE_ACQ to LOCKED. A spread at or above the threshold moves LOCKED back to PHASE_ACQ.
- R6: In FREQ_LOCK, PHASE_ACQ or LOCKED, a sample with |freq_err_i| >= freq_thr_i returns the state to FREQ_ACQ.
- R7: On every valid sample while a loop is enabled, that loop updates. The integrator becomes sat(integ + (err >>> ki)). The output becomes sat(new integ + (err >>> kp)). The two loops use separate shift inputs, and an output does not change while its loop is disabled.
- R8: When ref_ok_i is low in any state other than IDLE, the next state is HOLDOVER. On entry freq_ctrl_o takes the frequency integrator value. After that, neither control output changes while in HOLDOVER, and samples are ignored.
- R9: When ref_ok_i is high again in HOLDOVER, the next state is FREQ_ACQ. The frequency lock run starts again from zero.
- R10: restart_i has priority over every other input. It moves the state to IDLE and clears both integrators and both outputs. After it, lock is reached again through FREQ_ACQ, FREQ_LOCK and PHASE_ACQ.
- R11: Saturation clamps each integrator and output to [−2^(AW−1), 2^(AW−1)−1]. It never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_valid_i | input | 1 | Strobe marking a new error sample |
| freq_err_i | input | EW | Signed frequency error sample |
| phase_err_i | input | EW | Signed phase error sample |
| ref_ok_i | input | 1 | Reference present |
| restart_i | input | 1 | Restart request, clears the servo |
| freq_thr_i | input | EW | Frequency lock threshold (unsigned) |
| phase_thr_i | input | EW | Phase peak-to-peak threshold (unsigned) |
| kp_f_sh_i | input | SHW | Frequency loop proportional shift |
| ki_f_sh_i | input | SHW | Frequency loop integral shift |
| kp_p_sh_i | input | SHW | Phase loop proportional shift |
| ki_p_sh_i | input | SHW | Phase loop integral shift |
| state_o | output | 3 | Sequencer state code |
| freq_loop_en_o | output | 1 | Frequency loop enabled |
| phase_loop_en_o | output | 1 | Phase loop enabled |
| freq_ctrl_o | output | AW | Frequency actuator command |
| phase_ctrl_o | output | AW | Phase actuator command |

## Verification
The assertions assume that the thresholds and shift amounts stay constant while a lock run or a phase window is in progress. They also assume that restart_i and ref_ok_i are synchronous, single-clock-domain levels. The bench changes configuration only between scenarios, and only at negative edges. It builds error samples so that every lock run, every window boundary and every saturation step falls on a known cycle. It toggles the reference and restart one cycle at a time, never in the middle of an expected sample.

// File: rtl/servo_seq_pkg.sv
package servo_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FACQ   = 3'd1,
    ST_FLOCK  = 3'd2,
    ST_PACQ   = 3'd3,
    ST_LOCKED = 3'd4,
    ST_HOLD   = 3'd5
  } seq_state_e;

  function automatic logic freq_active(input seq_state_e s);
    return (s == ST_FACQ) || (s == ST_FLOCK) || (s == ST_PACQ) || (s == ST_LOCKED);
  endfunction

  function automatic logic phase_active(input seq_state_e s);
    return (s == ST_PACQ) || (s == ST_LOCKED);
  endfunction
endpackage

// File: rtl/pi_loop.sv
module pi_loop #(
  parameter int EW  = 16,
  parameter int AW  = 24,
  parameter int SHW = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 upd_i,
  input  logic                 hold_load_i,
  input  logic signed [EW-1:0] err_i,
  input  logic [SHW-1:0]       kp_sh_i,
  input  logic [SHW-1:0]       ki_sh_i,
  output logic signed [AW-1:0] acc_o,
  output logic signed [AW-1:0] out_o
);
  localparam logic signed [AW-1:0] MAXV = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = {1'b1, {(AW-1){1'b0}}};

  function automatic logic signed [AW-1:0] sat_add(input logic signed [AW-1:0] a,
                                                   input logic signed [AW-1:0] b);
    logic signed [AW:0] s;
    s = {a[AW-1], a} + {b[AW-1], b};
    if (s[AW] != s[AW-1]) return s[AW] ? MINV : MAXV;
    return s[AW-1:0];
  endfunction

  logic signed [AW-1:0] err_x, acc_q, out_q, acc_nxt, out_nxt;

  assign err_x   = {{(AW-EW){err_i[EW-1]}}, err_i};
  assign acc_nxt = sat_add(acc_q, err_x >>> ki_sh_i);
  assign out_nxt = sat_add(acc_nxt, err_x >>> kp_sh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      out_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      out_q <= '0;
    end else if (upd_i) begin
      acc_q <= acc_nxt;
      out_q <= out_nxt;
    end else if (hold_load_i) begin
      out_q <= acc_q;
    end
  end

  assign acc_o = acc_q;
  assign out_o = out_q;
endmodule

// File: rtl/freq_lock_det.sv
module freq_lock_det #(
  parameter int EW     = 16,
  parameter int FREQ_N = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 sample_i,
  input  logic signed [EW-1:0] err_i,
  input  logic [EW-1:0]        thr_i,
  output logic                 in_thr_o,
  output logic                 lock_o
);
  localparam int CW = $clog2(FREQ_N + 1);

  logic [CW-1:0] cnt_q;
  logic [EW:0]   ext, mag;

  assign ext      = {err_i[EW-1], err_i};
  assign mag      = err_i[EW-1] ? (~ext + 1'b1) : ext;
  assign in_thr_o = mag < {1'b0, thr_i};
  assign lock_o   = sample_i && in_thr_o && (cnt_q == CW'(FREQ_N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (sample_i) begin
      if (!in_thr_o || lock_o)      cnt_q <= '0;
      else                          cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/phase_window_det.sv
module phase_window_det #(
  parameter int EW      = 16,
  parameter int PHASE_M = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 sample_i,
  input  logic signed [EW-1:0] err_i,
  input  logic [EW-1:0]        thr_i,
  output logic                 done_o,
  output logic                 tight_o
);
  localparam int CW = $clog2(PHASE_M + 1);

  logic [CW-1:0]        cnt_q;
  logic signed [EW-1:0] mn_q, mx_q, mn_n, mx_n;
  logic [EW:0]          ptp;

  always_comb begin
    if (cnt_q == '0) begin
      mn_n = err_i;
      mx_n = err_i;
    end else begin
      mn_n = (err_i < mn_q) ? err_i : mn_q;
      mx_n = (err_i > mx_q) ? err_i : mx_q;
    end
  end

  assign ptp     = {mx_n[EW-1], mx_n} - {mn_n[EW-1], mn_n};
  assign done_o  = sample_i && (cnt_q == CW'(PHASE_M - 1));
  assign tight_o = ptp < {1'b0, thr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mn_q  <= '0;
      mx_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (sample_i) begin
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
      mn_q  <= mn_n;
      mx_q  <= mx_n;
    end
  end
endmodule

// File: rtl/servo_lock_seq.sv
module servo_lock_seq
  import servo_seq_pkg::*;
#(
  parameter int EW      = 16,
  parameter int AW      = 24,
  parameter int SHW     = 4,
  parameter int FREQ_N  = 8,
  parameter int PHASE_M = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_valid_i,
  input  logic signed [EW-1:0] freq_err_i,
  input  logic signed [EW-1:0] phase_err_i,
  input  logic                 ref_ok_i,
  input  logic                 restart_i,
  input  logic [EW-1:0]        freq_thr_i,
  input  logic [EW-1:0]        phase_thr_i,
  input  logic [SHW-1:0]       kp_f_sh_i,
  input  logic [SHW-1:0]       ki_f_sh_i,
  input  logic [SHW-1:0]       kp_p_sh_i,
  input  logic [SHW-1:0]       ki_p_sh_i,
  output logic [2:0]           state_o,
  output logic                 freq_loop_en_o,
  output logic                 phase_loop_en_o,
  output logic signed [AW-1:0] freq_ctrl_o,
  output logic signed [AW-1:0] phase_ctrl_o
);
  seq_state_e state_q, state_d;
  logic       f_en, p_en, samp_ok;
  logic       f_in, f_lock, w_done, w_tight;
  logic signed [AW-1:0] f_acc, p_acc;

  assign f_en    = freq_active(state_q);
  assign p_en    = phase_active(state_q);
  assign samp_ok = sample_valid_i && ref_ok_i && !restart_i;

  freq_lock_det #(.EW(EW), .FREQ_N(FREQ_N)) u_fdet (
    .clk_i, .rst_ni,
    .clr_i    (state_q != ST_FACQ),
    .sample_i (samp_ok && (state_q == ST_FACQ)),
    .err_i    (freq_err_i),
    .thr_i    (freq_thr_i),
    .in_thr_o (f_in),
    .lock_o   (f_lock)
  );

  phase_window_det #(.EW(EW), .PHASE_M(PHASE_M)) u_pwin (
    .clk_i, .rst_ni,
    .clr_i    (!p_en),
    .sample_i (samp_ok && p_en && f_in),
    .err_i    (phase_err_i),
    .thr_i    (phase_thr_i),
    .done_o   (w_done),
    .tight_o  (w_tight)
  );

  pi_loop #(.EW(EW), .AW(AW), .SHW(SHW)) u_fpi (
    .clk_i, .rst_ni,
    .clr_i       (restart_i),
    .upd_i       (samp_ok && f_en),
    .hold_load_i (!ref_ok_i && f_en),
    .err_i       (freq_err_i),
    .kp_sh_i     (kp_f_sh_i),
    .ki_sh_i     (ki_f_sh_i),
    .acc_o       (f_acc),
    .out_o       (freq_ctrl_o)
  );

  pi_loop #(.EW(EW), .AW(AW), .SHW(SHW)) u_ppi (
    .clk_i, .rst_ni,
    .clr_i       (restart_i),
    .upd_i       (samp_ok && p_en),
    .hold_load_i (1'b0),
    .err_i       (phase_err_i),
    .kp_sh_i     (kp_p_sh_i),
    .ki_sh_i     (ki_p_sh_i),
    .acc_o       (p_acc),
    .out_o       (phase_ctrl_o)
  );

  always_comb begin
    state_d = state_q;
    if (restart_i) begin
      state_d = ST_IDLE;
    end else if (!ref_ok_i) begin
      if (state_q != ST_IDLE) state_d = ST_HOLD;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_HOLD: state_d = ST_FACQ;
        ST_FACQ:  if (f_lock) state_d = ST_FLOCK;
        ST_FLOCK: if (samp_ok) state_d = f_in ? ST_PACQ : ST_FACQ;
        ST_PACQ: begin
          if (samp_ok && !f_in)        state_d = ST_FACQ;
          else if (w_done && w_tight)  state_d = ST_LOCKED;
        end
        ST_LOCKED: begin
          if (samp_ok && !f_in)        state_d = ST_FACQ;
          else if (w_done && !w_tight) state_d = ST_PACQ;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o         = state_q;
  assign freq_loop_en_o  = f_en;
  assign phase_loop_en_o = p_en;

  logic unused_acc;
  assign unused_acc = ^{f_acc, p_acc};
endmodule

// File: rtl/servo_lock_chk.sv
module servo_lock_chk #(
  parameter int EW = 16,
  parameter int AW = 24
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sample_valid_i,
  input logic                 ref_ok_i,
  input logic                 restart_i,
  input logic signed [EW-1:0] freq_err_i,
  input logic [EW-1:0]        freq_thr_i,
  input logic [2:0]           state_o,
  input logic                 freq_loop_en_o,
  input logic                 phase_loop_en_o,
  input logic signed [AW-1:0] freq_ctrl_o,
  input logic signed [AW-1:0] phase_ctrl_o
);
  logic [EW:0] f_mag;
  assign f_mag = freq_err_i[EW-1] ? (~{1'b1, freq_err_i} + 1'b1) : {1'b0, freq_err_i};

  assert_state_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd5);

  // R4: phase acquisition is entered only from frequency lock or from a failed locked window
  assert_phase_after_freq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && $past(state_o) != 3'd3) |-> ($past(state_o) == 3'd2 || $past(state_o) == 3'd4));

  // R3: frequency lock is entered from acquisition on a good sample
  assert_flock_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && $past(state_o) == 3'd1) |-> ($past(sample_valid_i) && $past(f_mag < {1'b0, freq_thr_i})));

  assert_locked_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && $past(state_o) != 3'd4) |-> $past(state_o) == 3'd3);

  assert_phase_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(phase_loop_en_o) && !$past(restart_i)) |-> $stable(phase_ctrl_o));

  assert_holdover_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5 && $past(state_o) == 3'd5) |-> ($stable(freq_ctrl_o) && $stable(phase_ctrl_o)));

  assert_holdover_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == 3'd5 && state_o != 3'd5) |-> (state_o == 3'd1 || state_o == 3'd0));

  assert_restart_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (state_o == 3'd0 && freq_ctrl_o == '0 && phase_ctrl_o == '0));

  assert_enable_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_loop_en_o |-> freq_loop_en_o);

  assert_ref_loss_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_ok_i && !restart_i && state_o != 3'd0) |=> state_o == 3'd5);
endmodule

bind servo_lock_seq servo_lock_chk #(.EW(EW), .AW(AW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .sample_valid_i  (sample_valid_i),
  .ref_ok_i        (ref_ok_i),
  .restart_i       (restart_i),
  .freq_err_i      (freq_err_i),
  .freq_thr_i      (freq_thr_i),
  .state_o         (state_o),
  .freq_loop_en_o  (freq_loop_en_o),
  .phase_loop_en_o (phase_loop_en_o),
  .freq_ctrl_o     (freq_ctrl_o),
  .phase_ctrl_o    (phase_ctrl_o)
);

// File: tb/tb_servo_lock_seq.sv
module tb_servo_lock_seq;
  localparam int EW = 16, AW = 24, SHW = 4, FN = 8, PM = 8;
  localparam longint MAXV = (64'sd1 <<< (AW-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (AW-1));

  logic clk = 1'b0, rst_n = 1'b0;
  logic sv = 1'b0, ref_ok = 1'b0, rst_req = 1'b0;
  logic signed [EW-1:0] ferr = '0, perr = '0;
  logic [EW-1:0] fthr = 16'd100, pthr = 16'd20;
  logic [SHW-1:0] kpf = 4'd2, kif = 4'd4, kpp = 4'd1, kip = 4'd3;
  logic [2:0] st;
  logic fen, pen;
  logic signed [AW-1:0] fctl, pctl;

  always #5 clk = ~clk;

  servo_lock_seq #(.EW(EW), .AW(AW), .SHW(SHW), .FREQ_N(FN), .PHASE_M(PM)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(sv), .freq_err_i(ferr), .phase_err_i(perr),
    .ref_ok_i(ref_ok), .restart_i(rst_req), .freq_thr_i(fthr), .phase_thr_i(pthr),
    .kp_f_sh_i(kpf), .ki_f_sh_i(kif), .kp_p_sh_i(kpp), .ki_p_sh_i(kip),
    .state_o(st), .freq_loop_en_o(fen), .phase_loop_en_o(pen),
    .freq_ctrl_o(fctl), .phase_ctrl_o(pctl));

  typedef struct { int st; longint fo; longint po; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  int ms = 0, fcnt = 0, pcnt = 0, pmin = 0, pmax = 0;
  longint facc = 0, fout = 0, pacc = 0, pout = 0;

  function automatic longint sat(longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // scoreboard driver: one cycle of stimulus plus expected outcome
  task automatic step(bit v, bit r, bit rs, int f, int p, string tag);
    bit fin, ok, fe, pe, tight;
    int nst, af;
    @(negedge clk);
    sv = v; ref_ok = r; rst_req = rs; ferr = 16'(f); perr = 16'(p);
    af = (f < 0) ? -f : f;
    fin = af < int'(fthr);
    ok = v && r && !rs;
    fe = ms inside {1, 2, 3, 4};
    pe = ms inside {3, 4};
    nst = ms;
    if (rs) begin
      nst = 0; facc = 0; fout = 0; pacc = 0; pout = 0;
    end else if (!r) begin
      if (ms != 0) nst = 5;
      if (fe) fout = facc;
    end else begin
      if (ok && fe) begin
        facc = sat(facc + (f >>> kif));
        fout = sat(facc + (f >>> kpf));
      end
      if (ok && pe) begin
        pacc = sat(pacc + (p >>> kip));
        pout = sat(pacc + (p >>> kpp));
      end
      case (ms)
        0, 5: nst = 1;
        1: if (ok) begin
             if (fin) begin
               fcnt++;
               if (fcnt == FN) nst = 2;
             end else fcnt = 0;
           end
        2: if (ok) nst = fin ? 3 : 1;
        3, 4: if (ok) begin
             if (!fin) nst = 1;
             else begin
               if (pcnt == 0) begin pmin = p; pmax = p; end
               else begin
                 if (p < pmin) pmin = p;
                 if (p > pmax) pmax = p;
               end
               pcnt++;
               if (pcnt == PM) begin
                 pcnt = 0;
                 tight = (pmax - pmin) < int'(pthr);
                 if (ms == 3 && tight) nst = 4;
                 if (ms == 4 && !tight) nst = 3;
               end
             end
           end
        default: ;
      endcase
    end
    if (nst != 1) fcnt = 0;
    if (nst != 3 && nst != 4) pcnt = 0;
    ms = nst;
    q.push_back('{nst, fout, pout, tag});
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(st == 3'(e.st), e.tag, "state", st, e.st);
        chk(fctl == AW'(e.fo), e.tag, "freq_ctrl", fctl, e.fo);
        chk(pctl == AW'(e.po), e.tag, "phase_ctrl", pctl, e.po);
        chk(fen == (e.st inside {1, 2, 3, 4}), e.tag, "freq_en", fen, e.st inside {1, 2, 3, 4});
        chk(pen == (e.st inside {3, 4}), e.tag, "phase_en", pen, e.st inside {3, 4});
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(st == 3'd0 && !fen && !pen && fctl == 0 && pctl == 0, "R1", "reset state", st, 0);
    rst_n = 1'b1;
    // R2: idle to frequency acquisition
    step(0, 1, 0, 0, 0, "R2");
    // R3: run broken by a bad sample, then a full run
    for (int i = 0; i < 5; i++) step(1, 1, 0, 40 - 15 * i, 0, "R3");
    step(1, 1, 0, 150, 0, "R3");
    for (int i = 0; i < FN; i++) step(1, 1, 0, (i % 2) ? -60 : 70, 0, "R3");
    // R4: frequency lock then phase acquisition
    step(1, 1, 0, 30, 5, "R4");
    // R5: wide window stays in acquisition, tight window locks
    for (int i = 0; i < PM; i++) step(1, 1, 0, 10, (i % 2) ? 40 : -40, "R5");
    for (int i = 0; i < PM; i++) step(1, 1, 0, -8, 100 + i, "R5");
    step(0, 1, 0, 0, 0, "R7");
    for (int i = 0; i < PM; i++) step(1, 1, 0, 20, (i == 3) ? 500 : 3, "R5");
    for (int i = 0; i < PM; i++) step(1, 1, 0, 20, -6 + i, "R5");
    // R6: frequency excursion drops back
    step(1, 1, 0, -300, 7, "R6");
    for (int i = 0; i < FN; i++) step(1, 1, 0, 90, 0, "R6");
    step(1, 1, 0, 90, 0, "R6");
    for (int i = 0; i < PM; i++) step(1, 1, 0, 5, 12, "R7");
    // R8: reference loss, samples ignored
    step(1, 0, 0, 50, 50, "R8");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 3000, -3000, "R8");
    // R9: reference back, restart the staged sequence
    step(0, 1, 0, 0, 0, "R9");
    for (int i = 0; i < FN - 1; i++) step(1, 1, 0, 11, 0, "R9");
    step(1, 1, 0, 400, 0, "R9");
    // R10: restart clears and re-sequences
    step(1, 1, 1, 20, 20, "R10");
    step(0, 1, 0, 0, 0, "R10");
    for (int i = 0; i < FN; i++) step(1, 1, 0, -25, 0, "R10");
    step(1, 1, 0, -25, 0, "R10");
    for (int i = 0; i < PM; i++) step(1, 1, 0, -25, -2, "R10");
    // R11: saturation in both directions
    step(1, 1, 1, 0, 0, "R11");
    @(negedge clk);
    fthr = 16'd1; kif = 4'd0; kpf = 4'd0;
    step(0, 1, 0, 0, 0, "R11");
    for (int i = 0; i < 300; i++) step(1, 1, 0, 32767, 0, "R11");
    for (int i = 0; i < 560; i++) step(1, 1, 0, -32768, 0, "R11");
    step(0, 1, 0, 0, 0, "R11");
    @(negedge clk);
    sv = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule